// File: doc/BRIEF.md
# Serial Boot Erase-Command Responder

This block is the target-side sequencer for a byte-serial boot protocol. It handles one request type: erasing the whole memory. A UART receiver delivers bytes to it, each with a flag that marks a framing or parity fault. The block answers through a UART transmitter using a valid/ready handshake. A session opens with a mode-select byte, which the block acknowledges. A command byte follows. The block echoes it if it is the erase command and refuses it otherwise. Next come twelve password bytes and one checksum byte. When the checksum is right and no password fault was seen, the block raises a one-cycle erase request and goes back to waiting for a new mode byte.

The twelve reference bytes sit in a small register bank that is loaded through a write port. A configuration input turns the password check on or off. When the check is off, the password bytes still count toward the checksum but never raise the password-fault flag. A one-byte holding stage sits between the receiver and the sequencer. It keeps the receiver enabled while a response is still waiting to be accepted, so the controller's next byte is not lost.

Top module: `boot_erase_responder`

## Requirements
- R1: A mode byte of 0x86 received without a receive fault is answered with the byte 0x86, and the block then treats the next byte as a command.
- R2: A mode byte of any other value, or one received with a fault, produces no response byte, and the block keeps waiting for a mode byte.
- R3: A command byte of 0x40 received without a fault is answered with 0x40, and the block moves on to collecting twelve password bytes.
- R4: A command byte received with a fault is answered with a byte whose low nibble is 0x8. The block then waits for another command byte.
- R5: A fault-free command byte other than 0x40 is answered with a byte whose low nibble is 0x1. The block then waits for another command byte. In R4 and R5 the high nibble is the high nibble of the previous byte received in the command slot of the same session, or 0 if there was none.
- R6: With pw_required low, password byte values never set pw_err.
- R7: With pw_required high, password byte k (k = 0..11, in arrival order) is compared with reference entry k. Any mismatch sets pw_err. pw_err stays set until the next command byte is accepted, and while it is set no erase request is issued.
- R8: The byte after the twelve password bytes must equal the two's complement of the 8-bit sum of the password bytes. On a mismatch, csum_err goes high and stays high until the next accepted mode byte, and no erase request is issued.
- R9: When the checksum matches and pw_err is low, erase_req is high for exactly one cycle and the block returns to waiting for a mode byte. No response byte is sent for the checksum.
- R10: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R11: rx_en is high whenever tx_valid rises. One byte received while a response waits is held, with rx_en low, and processed after that response is accepted.
- R12: After reset, tx_valid, erase_req, pw_err and csum_err are low, rx_en is high, and the block waits for a mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pw_required | input | 1 | Enables the password comparison |
| ref_we | input | 1 | Write strobe for the reference password bank |
| ref_idx | input | 4 | Reference entry written |
| ref_data | input | 8 | Reference byte written |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Framing or parity fault on the received byte |
| rx_en | output | 1 | Receiver may deliver a byte |
| tx_valid | output | 1 | Response byte valid |
| tx_ready | input | 1 | Transmitter accepts the response byte |
| tx_data | output | 8 | Response byte |
| erase_req | output | 1 | One-cycle erase request |
| pw_err | output | 1 | Sticky password mismatch flag |
| csum_err | output | 1 | Sticky checksum mismatch flag |

## Verification
The case hardest to reach from the ports is a new byte arriving while a response is still held by a stalled transmitter. The stimulus reaches it by lowering tx_ready, then sending the mode byte and the command byte back to back. The bench checks that the acknowledgement stays on the port unchanged, that rx_en drops while the second byte is held, and that both responses come out in order once the transmitter is released. Another case is the error-reply high nibble, which depends on the previous command byte. The vector table chains several rejected commands so that each reply carries the previous nibble.

// File: rtl/bootera_pkg.sv
package bootera_pkg;

  typedef enum logic [2:0] {
    ST_MODE,
    ST_CMD,
    ST_PW,
    ST_CSUM,
    ST_SEND
  } bootera_state_t;

  localparam logic [3:0] NIB_RX_FAULT  = 4'h8;
  localparam logic [3:0] NIB_BAD_CMD   = 4'h1;

endpackage

// File: rtl/bootera_rst_sync.sv
module bootera_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bootera_rx_hold.sv
module bootera_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_err,
  input  logic              take,
  output logic              hold_vld,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_err,
  output logic              ready
);

  logic              load;
  logic              vld_d;
  logic [DATA_W-1:0] data_d;
  logic              err_d;

  assign ready = !hold_vld;
  assign load  = in_valid && ready;

  always_comb begin
    vld_d  = hold_vld;
    data_d = hold_data;
    err_d  = hold_err;
    if (load) begin
      vld_d  = 1'b1;
      data_d = in_data;
      err_d  = in_err;
    end else if (take) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
      hold_err  <= 1'b0;
    end else begin
      hold_vld  <= vld_d;
      hold_data <= data_d;
      hold_err  <= err_d;
    end
  end

endmodule

// File: rtl/bootera_pw_bank.sv
module bootera_pw_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_en;
    assign wr_en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     entry_q[g] <= '0;
      else if (wr_en) entry_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx == IDX_W'(i)) rdata = entry_q[i];
    end
  end

endmodule

// File: rtl/bootera_csum.sv
module bootera_csum #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic              match
);

  logic [DATA_W-1:0] sum_q;
  logic [DATA_W-1:0] sum_d;
  logic [DATA_W-1:0] total;

  assign total = sum_q + din;
  assign match = (total == '0);

  always_comb begin
    sum_d = sum_q;
    if (clr)      sum_d = '0;
    else if (add) sum_d = total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

endmodule

// File: rtl/boot_erase_responder.sv
module boot_erase_responder #(
  parameter int          DATA_W      = 8,
  parameter int          PW_LEN      = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  MODE_CODE   = 8'h86,
  parameter logic [7:0]  ERASE_CMD   = 8'h40,
  localparam int         IDX_W       = $clog2(PW_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_required,
  input  logic              ref_we,
  input  logic [IDX_W-1:0]  ref_idx,
  input  logic [DATA_W-1:0] ref_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_err,
  output logic              rx_en,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              erase_req,
  output logic              pw_err,
  output logic              csum_err
);

  import bootera_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PW_LEN - 1);
  localparam int               HI_W     = DATA_W - 4;

  logic              rst_i_n;
  logic              hold_vld;
  logic [DATA_W-1:0] hold_data;
  logic              hold_err;
  logic              take;
  logic              sum_clr;
  logic              sum_add;
  logic              sum_match;
  logic [DATA_W-1:0] ref_byte;

  bootera_state_t    state_q, state_d;
  bootera_state_t    ret_q, ret_d;
  logic [DATA_W-1:0] txd_q, txd_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pwe_q, pwe_d;
  logic              cse_q, cse_d;
  logic              erase_q, erase_d;
  logic [HI_W-1:0]   hi_q, hi_d;

  bootera_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bootera_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .in_err    (rx_err),
    .take      (take),
    .hold_vld  (hold_vld),
    .hold_data (hold_data),
    .hold_err  (hold_err),
    .ready     (rx_en)
  );

  bootera_pw_bank #(.DATA_W(DATA_W), .DEPTH(PW_LEN), .IDX_W(IDX_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (ref_we),
    .widx  (ref_idx),
    .wdata (ref_data),
    .ridx  (idx_q),
    .rdata (ref_byte)
  );

  bootera_csum #(.DATA_W(DATA_W)) u_csum (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (sum_clr),
    .add   (sum_add),
    .din   (hold_data),
    .match (sum_match)
  );

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    txd_d   = txd_q;
    idx_d   = idx_q;
    pwe_d   = pwe_q;
    cse_d   = cse_q;
    hi_d    = hi_q;
    erase_d = 1'b0;
    take    = 1'b0;
    sum_clr = 1'b0;
    sum_add = 1'b0;
    case (state_q)
      ST_MODE: begin
        if (hold_vld) begin
          take = 1'b1;
          if (!hold_err && hold_data == MODE_CODE) begin
            txd_d   = MODE_CODE;
            ret_d   = ST_CMD;
            state_d = ST_SEND;
            hi_d    = '0;
            cse_d   = 1'b0;
          end
        end
      end
      ST_CMD: begin
        if (hold_vld) begin
          take    = 1'b1;
          hi_d    = hold_data[DATA_W-1 -: HI_W];
          state_d = ST_SEND;
          ret_d   = ST_CMD;
          if (hold_err) begin
            txd_d = {hi_q, NIB_RX_FAULT};
          end else if (hold_data == ERASE_CMD) begin
            txd_d   = ERASE_CMD;
            ret_d   = ST_PW;
            idx_d   = '0;
            pwe_d   = 1'b0;
            sum_clr = 1'b1;
          end else begin
            txd_d = {hi_q, NIB_BAD_CMD};
          end
        end
      end
      ST_PW: begin
        if (hold_vld) begin
          take    = 1'b1;
          sum_add = 1'b1;
          if (pw_required && hold_data != ref_byte) pwe_d = 1'b1;
          if (idx_q == LAST_IDX) state_d = ST_CSUM;
          else                   idx_d   = idx_q + IDX_W'(1);
        end
      end
      ST_CSUM: begin
        if (hold_vld) begin
          take    = 1'b1;
          state_d = ST_MODE;
          if (!sum_match)  cse_d   = 1'b1;
          else if (!pwe_q) erase_d = 1'b1;
        end
      end
      ST_SEND: begin
        if (tx_ready) state_d = ret_q;
      end
      default: state_d = ST_MODE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_MODE;
      ret_q   <= ST_MODE;
      txd_q   <= '0;
      idx_q   <= '0;
      pwe_q   <= 1'b0;
      cse_q   <= 1'b0;
      erase_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      txd_q   <= txd_d;
      idx_q   <= idx_d;
      pwe_q   <= pwe_d;
      cse_q   <= cse_d;
      erase_q <= erase_d;
      hi_q    <= hi_d;
    end
  end

  assign tx_valid  = (state_q == ST_SEND);
  assign tx_data   = txd_q;
  assign erase_req = erase_q;
  assign pw_err    = pwe_q;
  assign csum_err  = cse_q;

endmodule

// File: rtl/boot_erase_responder_chk.sv
module boot_erase_responder_chk #(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] MODE_CODE = 8'h86,
  parameter logic [7:0] ERASE_CMD = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              erase_req,
  input logic              pw_err,
  input logic              csum_err
);

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R11
  rx_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> rx_en);

  // R9
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  // R9
  erase_quiet_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !tx_valid);

  // R7
  erase_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !pw_err && !csum_err);

  // R7
  pw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pw_err) |-> tx_valid && tx_data == ERASE_CMD);

  // R8
  csum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csum_err) |-> tx_valid && tx_data == MODE_CODE);

endmodule

bind boot_erase_responder boot_erase_responder_chk #(
  .DATA_W    (DATA_W),
  .MODE_CODE (MODE_CODE),
  .ERASE_CMD (ERASE_CMD)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .erase_req (erase_req),
  .pw_err    (pw_err),
  .csum_err  (csum_err)
);

// File: tb/boot_erase_responder_tb_top.sv
`timescale 1ns/1ps
module boot_erase_responder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pw_required;
  logic       ref_we;
  logic [3:0] ref_idx;
  logic [7:0] ref_data;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_err;
  logic       rx_en;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] tx_data;
  logic       erase_req;
  logic       pw_err;
  logic       csum_err;

  int checks = 0;
  int errors = 0;
  int tx_cnt = 0;
  int erase_rises = 0;
  int erase_high = 0;
  logic       erase_prev = 1'b0;
  logic [7:0] tx_log [64];
  logic [7:0] ref_val [12];
  logic [7:0] pw_buf [12];

  always #2 clk = ~clk;

  boot_erase_responder dut_i (
    .clk (clk), .rst_n (rst_n), .pw_required (pw_required),
    .ref_we (ref_we), .ref_idx (ref_idx), .ref_data (ref_data),
    .rx_valid (rx_valid), .rx_data (rx_data), .rx_err (rx_err), .rx_en (rx_en),
    .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
    .erase_req (erase_req), .pw_err (pw_err), .csum_err (csum_err)
  );

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      if (tx_cnt < 64) tx_log[tx_cnt] = tx_data;
      tx_cnt = tx_cnt + 1;
    end
    if (erase_req) erase_high = erase_high + 1;
    if (erase_req && !erase_prev) erase_rises = erase_rises + 1;
    erase_prev = erase_req;
  end

  // {data, rx fault, response expected, response byte}
  localparam logic [17:0] VEC [7] = '{
    {8'h55, 1'b0, 1'b0, 8'h00},  // R2 wrong mode byte
    {8'h86, 1'b1, 1'b0, 8'h00},  // R2 mode byte with fault
    {8'h86, 1'b0, 1'b1, 8'h86},  // R1 accepted mode
    {8'h37, 1'b0, 1'b1, 8'h01},  // R5 first command, no previous nibble
    {8'hA0, 1'b1, 1'b1, 8'h38},  // R4 fault, nibble of 0x37
    {8'h5C, 1'b0, 1'b1, 8'hA1},  // R5 nibble of 0xA0
    {8'h40, 1'b0, 1'b1, 8'h40}   // R3 erase command
  };
  localparam string VEC_REQ [7] = '{"R2", "R2", "R1", "R5", "R4", "R5", "R3"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic e);
    @(negedge clk);
    while (!rx_en) @(negedge clk);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic send_expect(input logic [7:0] d, input logic e, input logic has,
                             input logic [7:0] exp, input string tag);
    int n0;
    n0 = tx_cnt;
    send_byte(d, e);
    wait_cyc(6);
    if (has) begin
      chk(tag, 32'(tx_cnt - n0), 32'd1);
      if (tx_cnt == n0 + 1) chk(tag, 32'(tx_log[n0]), 32'(exp));
    end else begin
      chk(tag, 32'(tx_cnt - n0), 32'd0);
    end
  endtask

  task automatic send_pw_csum(input logic bad_csum);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 12; i++) begin
      send_byte(pw_buf[i], 1'b0);
      s = s + pw_buf[i];
    end
    wait_cyc(4);
    s = ~s + 8'h01;
    if (bad_csum) s = s ^ 8'h01;
    send_byte(s, 1'b0);
    wait_cyc(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int e0;
    int h0;
    int n0;
    rst_n = 1'b0; pw_required = 1'b0; ref_we = 1'b0; ref_idx = '0; ref_data = '0;
    rx_valid = 1'b0; rx_data = '0; rx_err = 1'b0; tx_ready = 1'b1;
    for (int i = 0; i < 12; i++) ref_val[i] = 8'hC0 ^ 8'(i * 7);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_cyc(4);

    // R12 reset state
    chk("R12 tx_valid", 32'(tx_valid), 32'd0);
    chk("R12 erase_req", 32'(erase_req), 32'd0);
    chk("R12 pw_err", 32'(pw_err), 32'd0);
    chk("R12 csum_err", 32'(csum_err), 32'd0);
    chk("R12 rx_en", 32'(rx_en), 32'd1);

    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      ref_we = 1'b1; ref_idx = 4'(i); ref_data = ref_val[i];
    end
    @(posedge clk); #1 ref_we = 1'b0;

    for (int v = 0; v < 7; v++) begin
      send_expect(VEC[v][17:10], VEC[v][9], VEC[v][8], VEC[v][7:0], VEC_REQ[v]);
    end

    // R6 password ignored when not required
    for (int i = 0; i < 12; i++) pw_buf[i] = 8'(i * 13 + 1);
    e0 = erase_rises; h0 = erase_high;
    send_pw_csum(1'b0);
    chk("R6 pw_err", 32'(pw_err), 32'd0);
    chk("R9 erase count", 32'(erase_rises - e0), 32'd1);
    chk("R9 erase width", 32'(erase_high - h0), 32'd1);
    chk("R8 csum_err", 32'(csum_err), 32'd0);
    send_expect(8'h40, 1'b0, 1'b0, 8'h00, "R9 back to mode wait");

    // R7 mismatch on last password byte
    pw_required = 1'b1;
    send_expect(8'h86, 1'b0, 1'b1, 8'h86, "R1");
    send_expect(8'h40, 1'b0, 1'b1, 8'h40, "R3");
    for (int i = 0; i < 12; i++) pw_buf[i] = ref_val[i];
    pw_buf[11] = pw_buf[11] ^ 8'h01;
    e0 = erase_rises;
    send_pw_csum(1'b0);
    chk("R7 pw_err set", 32'(pw_err), 32'd1);
    chk("R7 no erase", 32'(erase_rises - e0), 32'd0);
    chk("R8 csum ok", 32'(csum_err), 32'd0);

    // R7 flag cleared by accepted command; R8 bad checksum
    send_expect(8'h86, 1'b0, 1'b1, 8'h86, "R1");
    chk("R7 pw_err held", 32'(pw_err), 32'd1);
    send_expect(8'h40, 1'b0, 1'b1, 8'h40, "R3");
    chk("R7 pw_err cleared", 32'(pw_err), 32'd0);
    for (int i = 0; i < 12; i++) pw_buf[i] = ref_val[i];
    e0 = erase_rises;
    send_pw_csum(1'b1);
    chk("R8 csum_err set", 32'(csum_err), 32'd1);
    chk("R8 no erase", 32'(erase_rises - e0), 32'd0);
    chk("R7 pw_err clean", 32'(pw_err), 32'd0);
    send_expect(8'h86, 1'b0, 1'b1, 8'h86, "R1");
    chk("R8 csum_err cleared", 32'(csum_err), 32'd0);

    // R7 matching password yields erase
    send_expect(8'h40, 1'b0, 1'b1, 8'h40, "R3");
    e0 = erase_rises;
    send_pw_csum(1'b0);
    chk("R7 match erase", 32'(erase_rises - e0), 32'd1);

    // R10 R11 stalled transmitter with a byte arriving behind the response
    @(posedge clk); #1 tx_ready = 1'b0;
    n0 = tx_cnt;
    send_byte(8'h86, 1'b0);
    send_byte(8'h40, 1'b0);
    wait_cyc(6);
    chk("R10 tx_valid held", 32'(tx_valid), 32'd1);
    chk("R10 tx_data held", 32'(tx_data), 32'h86);
    chk("R10 nothing accepted", 32'(tx_cnt - n0), 32'd0);
    chk("R11 rx_en low while holding", 32'(rx_en), 32'd0);
    @(posedge clk); #1 tx_ready = 1'b1;
    wait_cyc(8);
    chk("R11 two responses", 32'(tx_cnt - n0), 32'd2);
    if (tx_cnt - n0 == 2) begin
      chk("R11 first", 32'(tx_log[n0]), 32'h86);
      chk("R11 second", 32'(tx_log[n0 + 1]), 32'h40);
    end
    e0 = erase_rises;
    send_pw_csum(1'b0);
    chk("R9 erase after stall", 32'(erase_rises - e0), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule